// File: doc/BRIEF.md
# Five-Phase Digital Correlated Double Sampler

This block sits behind an analog-to-digital converter that oversamples an image-sensor output five times per pixel. For example, the converter runs at 5 MHz for a 1 MHz pixel rate. The block turns each group of five converter words into one pixel value by correlated double sampling in the digital domain.

Within a group, the first two words are taken while the sensor shows its reset level. The middle word falls on the transition and is thrown away. The last two words carry the video level. The block sums each pair at full width and subtracts the reset sum from the video sum. It then halves the difference with a floor shift, so the result is the difference of the two pair averages, with no rounding stage of its own. A one-bit order input swaps which pair counts as reset and which counts as video, for sensors timed the other way round. The arithmetic is the same in both orders.

Converter words enter on a valid/ready stream. A pixel-start marker travels with a word and forces that word to be the first of a group. Pixels leave on a valid/ready stream. An output pixel is held until it is taken. While it waits, the input ready is low, so a sample is never lost and never overwrites a pending result. When the output is not stalled, the input is always ready. A group that a marker cuts short is dropped, and a sticky error flag records the drop.

Top module: `cds_pixel`

## Requirements
- R1: Accepted samples (in_valid and in_ready both high at a clock edge) are numbered S1 to S5 in arrival order. After every fifth accepted sample, one pixel is produced, and the count restarts at S1.
- R2: With group_order = 0, out_pixel equals floor(((S4+S5) - (S1+S2)) / 2). The value is given as a two's complement number that is DATA_W+1 bits wide.
- R3: The value of S3 has no effect on out_pixel.
- R4: With group_order = 1, out_pixel equals floor(((S1+S2) - (S4+S5)) / 2). The order value is the one present when S5 is accepted.
- R5: out_valid rises on the clock edge that accepts S5, so it is visible in the cycle right after S5. When out_ready is high, out_valid stays high for exactly one cycle.
- R6: Cycles with in_valid low do not advance the sample count, and they do not change the result.
- R7: While out_valid is high and out_ready is low, in_ready is low, and out_valid and out_pixel hold their values. Once out_ready is high, the pixel is taken at that edge, and a new sample can be accepted at the same edge.
- R8: An accepted sample with in_marker = 1 becomes S1. If one to four samples of a group were already accepted, that partial group is discarded and err_sticky goes to 1. It stays at 1 until reset.
- R9: A marker on a sample that would be S1 anyway does not set err_sticky.
- R10: A synchronous active-high reset clears out_valid and err_sticky, and returns the count to S1. After reset, in_ready is 1 and the next accepted sample is S1 even without a marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| group_order | input | 1 | 0: first pair is reset level; 1: first pair is video level |
| in_valid | input | 1 | Converter word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | DATA_W | Unsigned converter word |
| in_marker | input | 1 | Word starts a new pixel group |
| out_valid | output | 1 | Pixel value present |
| out_ready | input | 1 | Downstream takes the pixel this cycle |
| out_pixel | output | DATA_W+1 | Signed pixel value, two's complement |
| err_sticky | output | 1 | A partial group was dropped since reset |

## Verification
Two functions can fall on the same clock edge. One is handing off a finished pixel. The other is accepting the first sample of the next group, either back to back or at the very edge where a stall is released. The bench streams groups without gaps, so each pixel leaves in the cycle in which the next group's S1 enters. In one case it holds out_ready low over a finished pixel, presents the next marked sample, and then raises out_ready. It then judges two things: the held pixel keeps its value while in_ready stays low, and both the released pixel and the following group's value match sums computed in the bench. The same arithmetic checks are swept over every combination of four 3-bit sample values in both orders.

// File: rtl/cds_pkg.sv
package cds_pkg;

  // Samples in one pixel group and the width of the phase index.
  localparam int unsigned GROUP_LEN = 5;
  localparam int unsigned PHASE_W   = $clog2(GROUP_LEN);
  // Two averaged pairs: one at the head and one at the tail of the group.
  localparam int unsigned NUM_PAIRS = 2;
  localparam int unsigned PAIR_STEP = GROUP_LEN - 2;

  typedef logic [PHASE_W-1:0] phase_t;

  typedef enum logic {
    ORDER_RESET_FIRST = 1'b0,
    ORDER_VIDEO_FIRST = 1'b1
  } order_e;

  // Phase index of the first sample of pair k.
  function automatic phase_t pair_base(int unsigned k);
    return phase_t'(k * PAIR_STEP);
  endfunction

endpackage

// File: rtl/cds_phase_ctr.sv
module cds_phase_ctr
  import cds_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   accept,
  input  logic   marker,
  output phase_t phase_eff,
  output logic   last_phase,
  output logic   err_sticky
);

  phase_t phase_q;
  logic   mid_group;

  assign mid_group  = (phase_q != '0);
  // A marker forces the current word to be the first of a group.
  assign phase_eff  = marker ? '0 : phase_q;
  assign last_phase = (phase_eff == phase_t'(GROUP_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= '0;
      err_sticky <= 1'b0;
    end else if (accept) begin
      phase_q <= last_phase ? '0 : phase_t'(phase_eff + 1'b1);
      if (marker && mid_group) begin
        err_sticky <= 1'b1;
      end
    end
  end

  // R1: the phase index never leaves the group
  assert_phase_range_R1: assert property (@(posedge clk) disable iff (rst)
    phase_q < phase_t'(GROUP_LEN));

  // R6: without an accepted word the phase does not move
  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(phase_q));

  // R8: the drop flag is sticky
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);

endmodule

// File: rtl/cds_pair_acc.sv
module cds_pair_acc #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned SUM_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              add,
  input  logic [DATA_W-1:0] data,
  output logic [SUM_W-1:0]  sum_next
);

  logic [SUM_W-1:0] sum_q;

  // Pair sum kept at full width, so no bit is lost before the subtraction.
  always_comb begin
    if (load) begin
      sum_next = SUM_W'(data);
    end else if (add) begin
      sum_next = sum_q + SUM_W'(data);
    end else begin
      sum_next = sum_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
    end else begin
      sum_q <= sum_next;
    end
  end

endmodule

// File: rtl/cds_sub_out.sv
module cds_sub_out
  import cds_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned SUM_W  = DATA_W + 1,
  localparam int unsigned DIFF_W = DATA_W + 2,
  localparam int unsigned PIX_W  = DATA_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  order_e           order,
  input  logic [SUM_W-1:0] head_sum,
  input  logic [SUM_W-1:0] tail_sum,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pixel
);

  logic [SUM_W-1:0]  ref_sum;
  logic [SUM_W-1:0]  sig_sum;
  logic [DIFF_W-1:0] diff;

  assign ref_sum = (order == ORDER_VIDEO_FIRST) ? tail_sum : head_sum;
  assign sig_sum = (order == ORDER_VIDEO_FIRST) ? head_sum : tail_sum;
  // Two's complement difference; dropping bit 0 is a floor halving.
  assign diff    = {1'b0, sig_sum} - {1'b0, ref_sum};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_pixel <= diff[DIFF_W-1:1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: a stalled pixel is held unchanged
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));

endmodule

// File: rtl/cds_pixel.sv
module cds_pixel
  import cds_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned SUM_W = DATA_W + 1,
  localparam int unsigned PIX_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              group_order,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_marker,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pixel,
  output logic              err_sticky
);

  logic             accept;
  phase_t           phase_eff;
  logic             last_phase;
  logic [SUM_W-1:0] pair_sum [NUM_PAIRS];

  // Input stalls only while a finished pixel is waiting.
  assign in_ready = !(out_valid && !out_ready);
  assign accept   = in_valid && in_ready;

  cds_phase_ctr u_phase (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .marker     (in_marker),
    .phase_eff  (phase_eff),
    .last_phase (last_phase),
    .err_sticky (err_sticky)
  );

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    logic pair_load;
    logic pair_add;
    assign pair_load = accept && (phase_eff == pair_base(k));
    assign pair_add  = accept && (phase_eff == phase_t'(pair_base(k) + 1'b1));

    cds_pair_acc #(.DATA_W(DATA_W)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .load     (pair_load),
      .add      (pair_add),
      .data     (in_data),
      .sum_next (pair_sum[k])
    );
  end

  cds_sub_out #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (accept && last_phase),
    .order     (order_e'(group_order)),
    .head_sum  (pair_sum[0]),
    .tail_sum  (pair_sum[NUM_PAIRS-1]),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_pixel (out_pixel)
  );

  // R5: a pixel appears only right after the fifth sample was taken
  assert_rise_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(accept && last_phase));

  // R5: with the sink ready the strobe lasts one cycle
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> !out_valid);

endmodule

// File: tb/cds_pixel_tb_top.sv
`timescale 1ns/1ps
module cds_pixel_tb_top;

  localparam int DW = 3;
  localparam int PW = DW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          group_order = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_marker = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [PW-1:0] out_pixel;
  logic          err_sticky;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [PW-1:0] exp_q [$];
  string         tag_q [$];

  always #10 clk = ~clk;

  cds_pixel #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .group_order(group_order),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_marker(in_marker), .out_valid(out_valid), .out_ready(out_ready),
    .out_pixel(out_pixel), .err_sticky(err_sticky)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  // Output monitor: every handed-off pixel is compared with the queue.
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected pixel", int'($signed(out_pixel)), 0);
      end else begin
        logic [PW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_pixel == e, t, int'($signed(out_pixel)), int'($signed(e)));
      end
    end
  end

  // Called at posedge+1; returns at posedge+1 after the word was accepted.
  task automatic send(int d, bit mk);
    in_valid  = 1'b1;
    in_data   = DW'(d);
    in_marker = mk;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid  = 1'b0;
    in_marker = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic logic [PW-1:0] expect_pix(bit ord, int s1, int s2, int s4, int s5);
    int d;
    d = ord ? (s1 + s2) - (s4 + s5) : (s4 + s5) - (s1 + s2);
    return PW'(d >>> 1);
  endfunction

  task automatic group(int s1, int s2, int s3, int s4, int s5, bit mk, int gap, string tag);
    exp_q.push_back(expect_pix(group_order, s1, s2, s4, s5));
    tag_q.push_back(tag);
    send(s1, mk);
    send(s2, 1'b0);
    if (gap > 0) idle(gap);
    send(s3, 1'b0);
    send(s4, 1'b0);
    send(s5, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [PW-1:0] held;
    int idx;
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
    chk(err_sticky == 1'b0, "R10 err in reset", err_sticky, 0);
    chk(in_ready == 1'b1, "R10 in_ready in reset", in_ready, 1);
    rst = 1'b0;
    idle(1);

    // R10: partial group cut by reset, next word is S1 without a marker
    send(7, 1'b0); send(7, 1'b0);
    rst = 1'b1; idle(1); rst = 1'b0;
    chk(err_sticky == 1'b0, "R10 err after reset", err_sticky, 0);
    group(1, 2, 7, 6, 5, 1'b0, 0, "R10 first group after reset");

    // R5: strobe timing, one cycle with sink ready
    group(0, 0, 0, 7, 7, 1'b0, 0, "R5 value");
    @(negedge clk);
    chk(out_valid == 1'b1, "R5 valid after S5", out_valid, 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 single cycle", out_valid, 0);
    @(posedge clk); #1;

    // R6: idle gaps inside a group, and a long gap before S5
    group(3, 5, 0, 2, 1, 1'b0, 4, "R6 gap mid group");
    exp_q.push_back(expect_pix(group_order, 6, 6, 1, 0));
    tag_q.push_back("R6 gap before S5");
    send(6, 1'b0); send(6, 1'b0); send(4, 1'b0); send(1, 1'b0);
    idle(6);
    send(0, 1'b0);

    // R9: markers on true S1 do not raise the flag
    group(2, 2, 2, 2, 2, 1'b1, 0, "R9 marked group");
    group(7, 6, 1, 0, 1, 1'b1, 0, "R9 marked group 2");
    idle(2);
    chk(err_sticky == 1'b0, "R9 no error on aligned marker", err_sticky, 0);

    // R7: back-pressure, then release on the edge a new S1 is taken
    out_ready = 1'b0;
    group(0, 1, 3, 7, 6, 1'b1, 0, "R7 released pixel");
    in_valid = 1'b1; in_data = DW'(4); in_marker = 1'b1;
    @(negedge clk);
    held = out_pixel;
    chk(out_pixel == expect_pix(1'b0, 0, 1, 7, 6), "R7 held value", int'($signed(out_pixel)),
        int'($signed(expect_pix(1'b0, 0, 1, 7, 6))));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R7 in_ready low in stall", in_ready, 0);
      chk(out_valid == 1'b1 && out_pixel == held, "R7 output stable",
          int'($signed(out_pixel)), int'($signed(held)));
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    exp_q.push_back(expect_pix(group_order, 4, 5, 0, 7));
    tag_q.push_back("R7 group after release");
    send(4, 1'b1); send(5, 1'b0); send(2, 1'b0); send(0, 1'b0); send(7, 1'b0);
    idle(2);
    chk(err_sticky == 1'b0, "R7 no error from release", err_sticky, 0);

    // R8: partial groups of two and four samples cut by markers
    send(5, 1'b0); send(5, 1'b0);
    group(1, 3, 5, 6, 6, 1'b1, 0, "R8 group after drop of two");
    idle(1);
    chk(err_sticky == 1'b1, "R8 error set", err_sticky, 1);
    send(1, 1'b0); send(1, 1'b0); send(1, 1'b0); send(1, 1'b0);
    group(7, 7, 0, 0, 0, 1'b1, 0, "R8 group after drop of four");
    group(4, 4, 4, 4, 4, 1'b0, 0, "R8 following group");
    idle(2);
    chk(err_sticky == 1'b1, "R8 error sticky", err_sticky, 1);
    rst = 1'b1; idle(1); rst = 1'b0;
    chk(err_sticky == 1'b0, "R10 error cleared by reset", err_sticky, 0);

    // R1 R2 R3 R4: sweep of all four-sample combinations in both orders
    idx = 0;
    for (int o = 0; o < 2; o++) begin
      group_order = o[0];
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          for (int c = 0; c < 8; c++)
            for (int d = 0; d < 8; d++) begin
              group(a, b, (a * 5 + d * 3 + idx) & 7, c, d, (idx % 3) == 0,
                    (idx % 11) == 0 ? 1 : 0,
                    o == 0 ? "R2 R3 R1 sweep order 0" : "R4 R3 R1 sweep order 1");
              idx++;
            end
    end
    idle(4);
    chk(exp_q.size() == 0, "R1 all pixels delivered", exp_q.size(), 0);
    chk(err_sticky == 1'b0, "R9 no error in sweep", err_sticky, 0);
    finish_run();
  end

endmodule